// File: doc/BRIEF.md
# Configurable SPI Master Byte Shifter

This block is the master side of a serial peripheral link. A host writes one byte into the data register, and the write alone starts a full-duplex exchange: the byte is sent most significant bit first on `sdo` while `sdi` is captured into the same shift register. When the last bit is in, the received byte is copied to a receive buffer. At that point a receive-full flag and an interrupt flag are raised.

Four run-time controls shape the waveform: the idle level of `sck`, whether the first bit is set up before the first clock edge or launched on it, whether `sdi` is captured in the middle or at the end of each bit, and the bit-rate source. The rate is a fixed division of the system clock or an external timer pulse divided by two. These settings are copied when a transfer starts, so changing them while a byte is in flight has no effect on that byte. With the serial output switched off, the block still clocks and captures bytes, which suits a receive-only listener.

Top module: `spi_master_core`

## Requirements
- R1: After reset `sck`, `sdo`, `sdo_oe` and `irq` are low and addresses 0 (receive buffer), 1 (control) and 2 (status) all read zero. A value written to address 1 reads back unchanged.
- R2: A write to address 0 while idle starts a transfer of that byte with no other command. Status bit 0 (busy) reads 1 from the next cycle until the byte completes.
- R3: Data leaves on `sdo` most significant bit first. With control bit 1 (early launch) set, bit 7 is on `sdo` from the cycle after the write and each later bit changes at the end of an odd half period. With it clear, every bit, the first included, changes at the end of an even half period (half 0, 2, ... 14).
- R4: Control bit 0 sets the idle level of `sck`: 0 gives low and 1 gives high. A transfer makes exactly 16 `sck` edges, one at the end of each of half periods 0 to 15, and leaves `sck` at the idle level. Polarity is taken at the start of a transfer.
- R5: Control bit 2 selects the capture point. With offset k = (1 - early launch) + (control bit 2), bit i (bit 7 first) is captured from `sdi` at the end of half period 2i + k. The received byte then reads from address 0.
- R6: Control bits 4:3 set the half period: 0 gives 2 system clocks, 1 gives 8, 2 gives 32, and 3 gives one half per `timer_tick` pulse. A transfer lasts 16 half periods, or 17 when k = 2. The rate is taken at the start of a transfer.
- R7: At the clock edge that ends the last half period, busy clears, the receive buffer loads, and status bit 1 (full), status bit 2 and the `irq` port are set.
- R8: A write to address 0 while busy is ignored and the byte in flight is unchanged. This includes a write on the completing edge. It sets status bit 3 (write collision).
- R9: Full is cleared by a read strobe (`rd_en`) of address 0. A load on the same edge as that read leaves full set.
- R10: Interrupt and collision flags clear only on a write to address 2 with bit 2 or bit 3 set respectively. A completion on the same edge as an interrupt clear leaves the interrupt set.
- R11: `sdo_oe` follows control bit 5. When it is 0, reception, timing and flags are unchanged.
- R12: `timer_tick` pulses while idle, or while a system-clock rate is in use, have no effect on `sck`, busy or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effect on address 0 only) |
| addr | input | 2 | Register address: 0 data, 1 control, 2 status |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Register read data (combinational on addr) |
| timer_tick | input | 1 | Single-cycle timer pulse for the timer rate |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| irq | output | 1 | Interrupt flag |

## Verification
Byte completion and host access can fall on the same clock edge. The bench provokes this in three ways by placing a host action in the cycle just before the final half-period edge: a receive-buffer read, an interrupt-clear write, or a new data write. For the read, the old byte must appear on `rdata` during that cycle, and full must still be set with the new byte afterwards. For the interrupt clear, the interrupt must survive. For the data write, the collision flag must set and no second transfer may begin.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    typedef enum logic [1:0] {
        RATE_DIV4  = 2'd0,
        RATE_DIV16 = 2'd1,
        RATE_DIV64 = 2'd2,
        RATE_TIMER = 2'd3
    } rate_sel_e;

    // control register layout, bit 0 at the bottom
    typedef struct packed {
        logic      out_en;
        rate_sel_e rate;
        logic      sample_late;
        logic      launch_early;
        logic      cpol;
    } xfer_cfg_t;

    localparam int CFG_W = $bits(xfer_cfg_t);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int ST_BUSY = 0;
    localparam int ST_FULL = 1;
    localparam int ST_IRQ  = 2;
    localparam int ST_WCOL = 3;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_mst_pkg::*;
#(
    parameter int HALF_A = 2,
    parameter int HALF_B = 8,
    parameter int HALF_C = 32
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  rate_sel_e rate,
    input  logic      timer_tick,
    output logic      half_tick
);
    localparam int CW = $clog2(HALF_C + 1);

    logic [CW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        case (rate)
            RATE_DIV4:  limit = CW'(HALF_A - 1);
            RATE_DIV16: limit = CW'(HALF_B - 1);
            RATE_DIV64: limit = CW'(HALF_C - 1);
            default:    limit = '0;
        endcase
        if (rate == RATE_TIMER) half_tick = run && timer_tick;
        else                    half_tick = run && (cnt_q == limit);
        if (!run || half_tick || rate == RATE_TIMER) cnt_d = '0;
        else                                          cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  xfer_cfg_t         cfg_in,
    input  logic              half_tick,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output rate_sel_e         act_rate
);
    localparam int NHALF = 2 * DATA_W;
    localparam int HW    = $clog2(NHALF + 1) + 1;

    typedef struct packed {
        logic              busy;
        logic [HW-1:0]     half;
        logic [DATA_W-1:0] shreg;
        logic              sck;
        logic              sdo;
        xfer_cfg_t         cfg;
    } eng_t;

    eng_t          q, n;
    logic [1:0]    off;
    logic [HW-1:0] rel, last;
    logic          smp, lau;

    always_comb begin
        n    = q;
        done = 1'b0;
        // half periods between launch reference and first capture
        off  = {1'b0, ~q.cfg.launch_early} + {1'b0, q.cfg.sample_late};
        rel  = q.half - HW'(off);
        last = (off == 2'd2) ? HW'(NHALF) : HW'(NHALF - 1);
        smp  = (q.half >= HW'(off)) && !rel[0] && (rel <= HW'(NHALF - 2));
        lau  = (q.half < HW'(NHALF - 1)) && (q.half[0] == q.cfg.launch_early);

        if (start && !q.busy) begin
            n.busy  = 1'b1;
            n.half  = '0;
            n.shreg = tx_data;
            n.cfg   = cfg_in;
            n.sck   = cfg_in.cpol;
            if (cfg_in.launch_early) n.sdo = tx_data[DATA_W-1];
        end else if (q.busy && half_tick) begin
            if (q.half < HW'(NHALF)) n.sck = ~q.sck;
            if (smp) n.shreg = {q.shreg[DATA_W-2:0], sdi};
            if (lau) n.sdo = n.shreg[DATA_W-1];
            if (q.half == last) begin
                n.busy = 1'b0;
                done   = 1'b1;
            end else begin
                n.half = q.half + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sck      = q.sck;
    assign sdo      = q.sdo;
    assign busy     = q.busy;
    assign rx_data  = n.shreg;
    assign act_rate = q.cfg.rate;

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HALF_A = 2,
    parameter int HALF_B = 8,
    parameter int HALF_C = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              timer_tick,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] rxbuf;
        logic              full;
        logic              irq;
        logic              wcol;
    } host_t;

    host_t             regs_q, regs_d;
    xfer_cfg_t         cfg_now;
    rate_sel_e         act_rate;
    logic              eng_busy, eng_done, half_tick, start_xfer, wr_data;
    logic              wcol_flag, full_flag;
    logic [DATA_W-1:0] rx_data;

    assign cfg_now    = xfer_cfg_t'(regs_q.ctrl[CFG_W-1:0]);
    assign wr_data    = wr_en && (addr == ADDR_DATA);
    assign start_xfer = wr_data && !eng_busy;

    spi_rate_gen #(
        .HALF_A(HALF_A), .HALF_B(HALF_B), .HALF_C(HALF_C)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .rate(act_rate),
        .timer_tick(timer_tick), .half_tick(half_tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start_xfer), .tx_data(wdata),
        .cfg_in(cfg_now), .half_tick(half_tick), .sdi(sdi), .sck(sck),
        .sdo(sdo), .busy(eng_busy), .done(eng_done), .rx_data(rx_data),
        .act_rate(act_rate)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en && addr == ADDR_CTRL) regs_d.ctrl = wdata;
        if (wr_data && eng_busy) regs_d.wcol = 1'b1;
        else if (wr_en && addr == ADDR_STAT && wdata[ST_WCOL]) regs_d.wcol = 1'b0;
        if (eng_done) begin
            regs_d.rxbuf = rx_data;
            regs_d.full  = 1'b1;
            regs_d.irq   = 1'b1;
        end else begin
            if (rd_en && addr == ADDR_DATA) regs_d.full = 1'b0;
            if (wr_en && addr == ADDR_STAT && wdata[ST_IRQ]) regs_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            ADDR_DATA: rdata = regs_q.rxbuf;
            ADDR_CTRL: rdata = regs_q.ctrl;
            ADDR_STAT: rdata = {{(DATA_W-4){1'b0}}, regs_q.wcol, regs_q.irq,
                                regs_q.full, eng_busy};
            default:   rdata = '0;
        endcase
    end

    assign sdo_oe    = cfg_now.out_en;
    assign irq       = regs_q.irq;
    assign wcol_flag = regs_q.wcol;
    assign full_flag = regs_q.full;

endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk
    import spi_mst_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       irq_clr_bit,
    input logic       sck,
    input logic       irq,
    input logic       busy,
    input logic       wcol,
    input logic       full
);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA && !busy) |=> busy);

    a_r4_sck_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(wr_en && addr == ADDR_DATA)) |=> $stable(sck));

    a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (irq && full));

    a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DATA && busy) |=> wcol);

    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(rd_en && addr == ADDR_DATA)) |=> full);

    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && addr == ADDR_STAT && irq_clr_bit)) |=> irq);

endmodule

bind spi_master_core spi_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .irq_clr_bit(wdata[2]), .sck(sck), .irq(irq), .busy(eng_busy),
    .wcol(wcol_flag), .full(full_flag)
);

// File: tb/tb_spi_master_core.sv
module tb_spi_master_core;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, rd_en, timer_tick, sdi;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       sck, sdo, sdo_oe, irq;
    int         tests = 0, fails = 0;
    logic [7:0] model_rx = 8'h00;

    always #10 clk = ~clk;

    spi_master_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .timer_tick(timer_tick), .sdi(sdi),
        .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic sdi_val(input int h, input int off, input logic [7:0] rx);
        int s = h - off;
        if (s < 0)                         return ~rx[7];
        if (s > 14)                        return ~rx[0];
        if (s % 2 == 0)                    return rx[7 - s/2];
        return ~rx[7 - (s-1)/2];
    endfunction

    task automatic run_xfer(input logic [5:0] cfgv, input logic [7:0] tx,
                            input logic [7:0] rx, input int endop, input bit disturb);
        bit   cp    = cfgv[0];
        bit   early = cfgv[1];
        bit   late  = cfgv[2];
        int   rsel  = int'(cfgv[4:3]);
        bit   oe    = cfgv[5];
        int   hc    = (rsel == 0) ? 2 : (rsel == 1) ? 8 : (rsel == 2) ? 32 : 3;
        int   off   = (early ? 0 : 1) + (late ? 1 : 0);
        int   last  = (off == 2) ? 16 : 15;
        int   total = (last + 1) * hc;
        int   e_sck = 0, e_sdo = 0, e_oe = 0, e_busy = 0;
        logic [7:0] v;
        logic       s0;

        host_write(ADDR_CTRL_TB, {2'b00, cfgv});
        peek(ADDR_CTRL_TB, v);
        check(v == {2'b00, cfgv}, "R1", "control readback", v, cfgv);

        // R12: stray tick while idle
        timer_tick = 1'b1; s0 = sck;
        @(posedge clk);
        @(negedge clk);
        timer_tick = 1'b0;
        peek(2'd2, v);
        check(sck == s0 && v[0] == 1'b0, "R12", "idle tick effect", {v[0], sck}, {1'b0, s0});

        wr_en = 1'b1; addr = 2'd0; wdata = tx; sdi = sdi_val(0, off, rx);
        @(posedge clk);
        for (int k = 0; k <= total; k++) begin
            int  n = k / hc;
            int  tg = (n > 16) ? 16 : n;
            bit  bchk = 1'b1;
            int  idx;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0; addr = 2'd2;
            timer_tick = (k % 3 == 2);
            sdi = sdi_val(n, off, rx);
            if (disturb && k == 3) begin
                wr_en = 1'b1; addr = 2'd1; wdata = {2'b00, cfgv ^ 6'b001001}; bchk = 1'b0;
            end
            if (disturb && k == 5) begin
                wr_en = 1'b1; addr = 2'd0; wdata = 8'h3C; bchk = 1'b0;
            end
            if (k == total - 1 && endop != 0) begin
                bchk = 1'b0;
                if (endop == 1) begin
                    addr = 2'd0; rd_en = 1'b1;
                    #1 check(rdata == model_rx, "R9", "old byte during read", rdata, model_rx);
                end else if (endop == 2) begin
                    wr_en = 1'b1; addr = 2'd2; wdata = 8'h04;
                end else begin
                    wr_en = 1'b1; addr = 2'd0; wdata = 8'h99;
                end
            end
            #1;
            if (sck != (cp ^ tg[0])) e_sck++;
            if (early || n >= 1) begin
                idx = early ? n / 2 : (n - 1) / 2;
                if (idx > 7) idx = 7;
                if (sdo != tx[7 - idx]) e_sdo++;
            end
            if (sdo_oe != oe) e_oe++;
            if (bchk && rdata[0] != (k < total)) e_busy++;
        end
        timer_tick = 1'b0;
        check(e_sck == 0, "R4", "sck edge mismatches", e_sck, 0);
        check(e_sdo == 0, "R3", "sdo bit mismatches", e_sdo, 0);
        check(e_oe == 0, "R11", "sdo_oe mismatches", e_oe, 0);
        check(e_busy == 0, "R6", "busy window mismatches (R2 start)", e_busy, 0);

        peek(2'd2, v);
        check(v[0] == 1'b0, "R7", "busy after completion", v[0], 0);
        check(v[1] == 1'b1, "R9", "full after load", v[1], 1);
        check(v[2] == 1'b1 && irq, "R10", "irq after completion", {v[2], irq}, 2'b11);
        check(v[3] == (disturb || endop == 3), "R8", "collision flag", v[3],
              (disturb || endop == 3));
        check(sck == cp, "R4", "sck back at idle", sck, cp);

        host_read(2'd0, v);
        check(v == rx, "R5", "received byte", v, rx);
        model_rx = rx;
        peek(2'd2, v);
        check(v[1] == 1'b0, "R9", "full cleared by read", v[1], 0);
        host_write(2'd2, 8'h0C);
        peek(2'd2, v);
        check(v[3:2] == 2'b00 && !irq, "R10", "flags after clear", {v[3:2], irq}, 0);
    endtask

    localparam logic [1:0] ADDR_CTRL_TB = 2'd1;

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0;
        wdata = 8'h00; timer_tick = 1'b0; sdi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 3; a++) begin
            peek(2'(a), v);
            check(v == 8'h00, "R1", "register after reset", v, 0);
        end
        check({sck, sdo, sdo_oe, irq} == 4'b0000, "R1", "outputs after reset",
              {sck, sdo, sdo_oe, irq}, 0);

        for (int c = 0; c < 64; c++) begin
            logic [7:0] tx = 8'(c * 37 + 5);
            logic [7:0] rx = (c % 16 == 0) ? 8'hFF : (c % 16 == 1) ? 8'h00
                             : 8'(c * 91 + 60);
            run_xfer(6'(c), tx, rx, c % 4, (c % 5 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule